// File: doc/BRIEF.md
# Clock Status Capture Register with Interrupt

This block is the read-only status register of a clock-management device. Every cycle it samples three live inputs: a per-clock status bus with one bit for each monitored clock, a PLL lock indicator, and a 2-bit status that shows which reference input is selected. The per-clock bits are latched sticky. An internal interrupt flag records three kinds of event: a sticky bit becoming set, a loss of lock, and a change of the select status.

A host reads the register by pulsing a read strobe. The byte it gets is a snapshot taken at that strobe. The same read clears the interrupt flag. The sticky bits are cleared only by a one-cycle clear pulse that comes from a neighbouring mode register. An enable bit from a device configuration register decides whether the flag reaches the active-low interrupt pin.

Top module: `clkmon_status_reg`

## Requirements
- R1: Read data layout: bit 7 is the interrupt flag. Bits 6..3 are the sticky bits for clocks 3..0, so clock 0 is at bit 3. Bit 2 reads 1 when the lock input is low. Bits 1..0 mirror the select status.
- R2: A per-clock bit is set by its input being high at a clock edge. It then stays set after the input returns low.
- R3: A one-cycle clear pulse empties every sticky bit whose input is low.
- R4: The interrupt flag is set in the cycle after a sticky bit changes from clear to set.
- R5: The interrupt flag is set in the cycle after the lock input falls. A lock input that stays low does not set the flag again after a read, and a rising lock input raises no event.
- R6: The interrupt flag is set in the cycle after either select status bit changes.
- R7: A read strobe returns, from the following cycle on, the register value as it stood before the strobe, and clears the flag.
- R8: An event in the same cycle as a clearing read leaves the flag set.
- R9: The interrupt pin is low exactly when the flag is set and the enable input is 1. Otherwise the pin is high.
- R10: After synchronous reset the sticky bits and the flag are clear. Input levels present during reset raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_stat_i | input | 4 | Live per-clock status, one bit per clock |
| lock_i | input | 1 | PLL lock indicator, 1 = locked |
| sel_stat_i | input | 2 | Live reference-select status |
| rd_stb_i | input | 1 | Host read strobe for the register |
| rd_data_o | output | 8 | Snapshot taken at the last read strobe |
| sticky_clr_i | input | 1 | Clear pulse for the sticky bits |
| irq_en_i | input | 1 | Interrupt pin enable |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
The hardest case to reach is a new event arriving in the very cycle a read clears the flag. In that case the captured byte must show the old flag, and the flag must survive the read. The bench raises the read strobe and changes the select status at the same edge. It then reads twice more to see the flag present and then gone. Lock loss followed by a lock that stays low is also held for several cycles, which shows that a level does not act as a repeated edge.

// File: rtl/clkmon_pkg.sv
// Shared widths for the clock status register.
// Assumes one status bit per monitored clock and a binary select status.
package clkmon_pkg;
    localparam int unsigned CLKMON_NCLK  = 4;
    localparam int unsigned CLKMON_SELW  = 2;
    localparam int unsigned CLKMON_REGW  = CLKMON_NCLK + CLKMON_SELW + 2;
endpackage

// File: rtl/clkmon_sticky.sv
// Sticky capture of per-clock status bits.
// A bit is set by its input and held until the clear pulse. The clear pulse
// does not beat an input that is still high. evt_set_o flags a 0->1 transition.
module clkmon_sticky #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat_i,
    input  logic         clr_i,
    output logic [N-1:0] sticky_o,
    output logic         evt_set_o
);
    logic [N-1:0] sticky_q;
    logic [N-1:0] base;

    // Value the bits hold before new inputs are merged in.
    always_comb base = clr_i ? '0 : sticky_q;

    // Latch set requests and apply the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= base | stat_i;
    end

    // Newly set bit detection.
    always_comb evt_set_o = |(stat_i & ~base);

    assign sticky_o = sticky_q;

    // R2: without a clear, no set bit ever drops.
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
    // R3: after a clear, only bits with a high input can be set.
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((sticky_q & ~$past(stat_i)) == '0));
endmodule

// File: rtl/clkmon_edge_det.sv
// Edge detection on the lock indicator and the select status.
// Keeps registered copies. During reset the copies load the live inputs, so
// levels present at reset are not taken as edges.
module clkmon_edge_det #(
    parameter int unsigned SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_i,
    input  logic [SW-1:0] sel_i,
    output logic          lock_q_o,
    output logic [SW-1:0] sel_q_o,
    output logic          evt_lock_o,
    output logic          evt_sel_o
);
    logic          lock_q;
    logic [SW-1:0] sel_q;

    // History registers; always track the inputs, reset included.
    always_ff @(posedge clk) begin
        lock_q <= lock_i;
        sel_q  <= sel_i;
    end

    // Falling lock and any select change are events; nothing fires in reset.
    always_comb begin
        evt_lock_o = rst_n && lock_q && !lock_i;
        evt_sel_o  = rst_n && (sel_q != sel_i);
    end

    assign lock_q_o = lock_q;
    assign sel_q_o  = sel_q;

    // R5: a steady low lock raises no lock event.
    a_r5_no_level_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !lock_i) |-> !evt_lock_o);
endmodule

// File: rtl/clkmon_irq_flag.sv
// Interrupt flag: set by any event, cleared by a host read. An event wins
// over a read in the same cycle.
module clkmon_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_stb_i,
    output logic flag_o
);
    logic flag_q;

    // Set on an event, clear on a read; the event has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (evt_i)    flag_q <= 1'b1;
        else if (rd_stb_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R8: an event always leaves the flag set, read or not.
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_q);
    // R7: a read without an event clears the flag.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !evt_i) |=> !flag_q);
    // R10: the flag rises only because of an event.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !evt_i) |=> !flag_q);
endmodule

// File: rtl/clkmon_status_reg.sv
// Status register for a clock-management device. It combines the sticky
// per-clock bits, the lock and select edge detectors and the interrupt flag.
// It returns a snapshot taken at the read strobe and drives the gated,
// active-low interrupt pin. Assumes all inputs are synchronous to clk.
module clkmon_status_reg
    import clkmon_pkg::*;
#(
    parameter int unsigned N_CLK = CLKMON_NCLK,
    parameter int unsigned SEL_W = CLKMON_SELW,
    localparam int unsigned REG_W = N_CLK + SEL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CLK-1:0] clk_stat_i,
    input  logic             lock_i,
    input  logic [SEL_W-1:0] sel_stat_i,
    input  logic             rd_stb_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             sticky_clr_i,
    input  logic             irq_en_i,
    output logic             irq_n_o
);
    logic [N_CLK-1:0] sticky;
    logic             evt_set, evt_lock, evt_sel, evt_any;
    logic             lock_q;
    logic [SEL_W-1:0] sel_q;
    logic             flag;
    logic [REG_W-1:0] reg_now;
    logic [REG_W-1:0] rd_q;

    clkmon_sticky #(.N(N_CLK)) u_sticky (
        .clk(clk), .rst_n(rst_n), .stat_i(clk_stat_i), .clr_i(sticky_clr_i),
        .sticky_o(sticky), .evt_set_o(evt_set)
    );

    clkmon_edge_det #(.SW(SEL_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .sel_i(sel_stat_i),
        .lock_q_o(lock_q), .sel_q_o(sel_q),
        .evt_lock_o(evt_lock), .evt_sel_o(evt_sel)
    );

    // Any of the three event types sets the flag.
    always_comb evt_any = evt_set | evt_lock | evt_sel;

    clkmon_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_any), .rd_stb_i(rd_stb_i),
        .flag_o(flag)
    );

    // Register image: flag, sticky bits, inverted lock, select status.
    always_comb reg_now = {flag, sticky, ~lock_q, sel_q};

    // Snapshot the image at the read strobe, before the flag clears.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_q <= '0;
        else if (rd_stb_i) rd_q <= reg_now;
    end

    assign rd_data_o = rd_q;

    // Pin is active-low and gated by the enable.
    always_comb irq_n_o = !(flag && irq_en_i);

    // R9: a disabled interrupt keeps the pin high.
    a_r9_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> irq_n_o);
    // R5: a falling lock input sets the flag on the next edge.
    a_r5_lock_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_i) |=> flag);
    // R6: a select change sets the flag on the next edge.
    a_r6_sel_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_stat_i) |=> flag);
    // R7: the snapshot holds between reads.
    a_r7_snapshot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(rd_data_o));
endmodule

// File: tb/sim_clkmon_status_reg.sv
module sim_clkmon_status_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] clk_stat;
    logic       lock;
    logic [1:0] sel;
    logic       rd_stb;
    logic [7:0] rd_data;
    logic       sclr;
    logic       irq_en;
    logic       irq_n;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    clkmon_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .clk_stat_i(clk_stat), .lock_i(lock),
        .sel_stat_i(sel), .rd_stb_i(rd_stb), .rd_data_o(rd_data),
        .sticky_clr_i(sclr), .irq_en_i(irq_en), .irq_n_o(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic rd(output logic [7:0] d);
        rd_stb = 1'b1;
        tick(1);
        rd_stb = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rst_n = 1'b0; clk_stat = 4'b0; lock = 1'b1; sel = 2'b10;
        rd_stb = 1'b0; sclr = 1'b0; irq_en = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R10 pin idle after reset", {7'b0, irq_n}, 8'h01);
        rd(d);
        chk("R10/R1 reset image", d, 8'h02);
    endtask

    task automatic t_sticky;
        logic [7:0] d;
        clk_stat = 4'b0010; tick(1); clk_stat = 4'b0;
        tick(1);
        chk("R9 pin low with flag set", {7'b0, irq_n}, 8'h00);
        rd(d);
        chk("R2/R4 sticky set raises flag", d, 8'h92);
        rd(d);
        chk("R7/R2 flag cleared, bit kept", d, 8'h12);
        chk("R9 pin high after clear", {7'b0, irq_n}, 8'h01);
        sclr = 1'b1; tick(1); sclr = 1'b0;
        rd(d);
        chk("R3 clear empties sticky bits", d, 8'h02);
        clk_stat = 4'b1001; tick(1); clk_stat = 4'b0;
        rd(d);
        chk("R1/R4 clocks 3 and 0 positions", d, 8'hCA);
        sclr = 1'b1; tick(1); sclr = 1'b0;
        rd(d);
        chk("R3 second clear", d, 8'h02);
    endtask

    task automatic t_lock;
        logic [7:0] d;
        lock = 1'b0; tick(1);
        rd(d);
        chk("R5 lock loss flags", d, 8'h86);
        tick(5);
        rd(d);
        chk("R5 steady low no retrigger", d, 8'h06);
        lock = 1'b1; tick(2);
        rd(d);
        chk("R5 lock rise no event", d, 8'h02);
    endtask

    task automatic t_sel;
        logic [7:0] d;
        sel = 2'b11; tick(1);
        rd(d);
        chk("R6 select change flags", d, 8'h83);
        rd(d);
        chk("R7 flag cleared by read", d, 8'h03);
    endtask

    task automatic t_gate;
        logic [7:0] d;
        irq_en = 1'b0; sel = 2'b01; tick(2);
        chk("R9 disabled pin stays high", {7'b0, irq_n}, 8'h01);
        irq_en = 1'b1; #1;
        chk("R9 enable shows pending flag", {7'b0, irq_n}, 8'h00);
        rd(d);
        chk("R6 flag kept while masked", d, 8'h81);
    endtask

    task automatic t_race;
        logic [7:0] d;
        sel = 2'b00; rd(d);
        chk("R7 snapshot holds pre-read flag", d, 8'h01);
        rd(d);
        chk("R8 event beats clearing read", d, 8'h80);
        rd(d);
        chk("R8 flag then cleared", d, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sticky();
        t_lock();
        t_sel();
        t_gate();
        t_race();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule